// File: doc/BRIEF.md
# SIMD Doubleword Move Unit

This unit executes a decoded instruction that moves one 32-bit word between the integer side and the SIMD side of a core. It holds three register files of eight entries each: 32-bit general registers, 64-bit "narrow" SIMD registers and 128-bit "wide" SIMD registers. The opcode byte that follows the 0F escape chooses the direction. The operand-size prefix flag chooses the wide or the narrow SIMD class. A ModRM-style byte names the SIMD register and either a general register or a memory word. The memory word's address is taken from the general register named in the r/m field.

Loading into a SIMD register places the word in bits 31:0 and clears every bit above. Storing from a SIMD register sends only its bits 31:0. Fault checks come before any write. They use the emulation, task-switched and save-area-enable control bits, a pending-floating-point-fault input, and three fault inputs from address translation. One one-hot fault code and one done strobe come back per instruction. An integer writeback port loads the general registers. A registered read-out port exposes every register to the rest of the pipeline. A build parameter drops the wide class, and the prefixed forms then act on the narrow registers.

Top module: `simd_dword_mover`

## Requirements
- R1: Opcode 6E with no prefix writes narrow register `reg` (ModRM bits 5:3) with {32'b0, src}. When ModRM bits 7:6 are 11, src is general register `rm` (bits 2:0). Otherwise src is `mem_rdata`, read at `mem_addr` = general register `rm`.
- R2: Opcode 6E with the prefix (wide class built) writes wide register `reg` with {96'b0, src}, where src is taken as in R1.
- R3: Opcode 7E sends bits 31:0 of SIMD register `reg` to its destination. The source is the narrow register without the prefix and the wide register with it. With ModRM bits 7:6 = 11 the destination is general register `rm`. Otherwise `mem_we` pulses in the issue cycle with `mem_addr` = general register `rm`.
- R4: `out_done` is high exactly in the cycle after a cycle with `in_valid` high. `out_fault` is then one-hot or zero (zero means success), with bit 0 = invalid opcode, bit 1 = device not available, bit 2 = FPU fault, bit 3 = general protection, bit 4 = stack fault, bit 5 = page fault.
- R5: An invalid-opcode fault is raised when `cr0_em` is set, when the opcode is neither 6E nor 7E, or when a prefixed form (wide class built) has `cr4_osfxsr` clear. It outranks every other fault.
- R6: With no invalid-opcode fault, `cr0_ts` raises a device-not-available fault.
- R7: `fpu_pending` raises an FPU fault only for narrow-class forms. Prefixed wide-class forms complete normally while it is set.
- R8: `ext_gp`, `ext_ss` and `ext_pf` count only for memory forms (ModRM bits 7:6 not 11). They rank below the FPU fault and, among themselves, in that order. Register forms ignore them.
- R9: Any fault suppresses every register write and the memory write of that instruction.
- R10: With `HAS_XMM` = 0, the prefixed forms act on the narrow registers, and neither `cr4_osfxsr` nor the prefix raises a fault.
- R11: `wb_en` writes `wb_data` into general register `wb_idx`. `rd_data` shows, one cycle after `rd_cls`/`rd_idx`, the named register zero-extended. `rd_cls` is 0 = general, 1 = narrow, 2 = wide, and 3 reads as zero.
- R12: Synchronous reset clears all registers, `out_done`, `out_fault` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_opcode | input | 8 | Opcode byte after the 0F escape |
| in_opsize | input | 1 | Operand-size prefix present |
| in_modrm | input | 8 | mode / reg / r/m selector |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| cr4_osfxsr | input | 1 | Wide-state save enable bit |
| fpu_pending | input | 1 | Unmasked FPU fault pending |
| ext_gp | input | 1 | Protection fault from address checks |
| ext_ss | input | 1 | Stack fault from address checks |
| ext_pf | input | 1 | Page fault from translation |
| wb_en | input | 1 | Integer writeback enable |
| wb_idx | input | 3 | Integer writeback register |
| wb_data | input | 32 | Integer writeback value |
| rd_cls | input | 2 | Read-out class |
| rd_idx | input | 3 | Read-out register |
| rd_data | output | 128 | Registered read-out value |
| mem_addr | output | 32 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| out_done | output | 1 | Instruction completed |
| out_fault | output | 6 | One-hot fault code |

## Verification
The assertions assume that an instruction's memory word answers in the same cycle its address appears. They also assume that the writeback port never targets the general register an instruction writes in that same cycle. They judge the fault code only on the cycle after `in_valid`. The bench changes every input on the falling edge, answers reads from a small combinational memory array, and schedules writeback loads in cycles without an instruction. The translation fault inputs are raised together with register forms only where the point of the check is that they are ignored.

// File: rtl/simd_mv_pkg.sv
package simd_mv_pkg;
  localparam int FLT_W = 6;
  localparam int FB_UD = 0;
  localparam int FB_NM = 1;
  localparam int FB_MF = 2;
  localparam int FB_GP = 3;
  localparam int FB_SS = 4;
  localparam int FB_PF = 5;

  localparam logic [7:0] OPC_TO_SIMD   = 8'h6E;
  localparam logic [7:0] OPC_FROM_SIMD = 8'h7E;

  typedef enum logic [1:0] {
    CLS_GPR    = 2'd0,
    CLS_NARROW = 2'd1,
    CLS_WIDE   = 2'd2,
    CLS_NONE   = 2'd3
  } rcls_e;
endpackage

// File: rtl/simd_mv_decode.sv
module simd_mv_decode
  import simd_mv_pkg::*;
#(
  parameter bit HAS_XMM = 1'b1
) (
  input  logic [7:0]       opcode,
  input  logic             opsize,
  input  logic [7:0]       modrm,
  input  logic             em,
  input  logic             ts,
  input  logic             osfxsr,
  input  logic             fpu_pend,
  input  logic             ext_gp,
  input  logic             ext_ss,
  input  logic             ext_pf,
  output logic             to_simd,
  output logic             wide,
  output logic             is_mem,
  output logic [2:0]       simd_idx,
  output logic [2:0]       gpr_idx,
  output logic [FLT_W-1:0] fault
);
  logic             known;
  logic [FLT_W-1:0] raw;
  logic             hit;

  always_comb begin
    to_simd  = (opcode == OPC_TO_SIMD);
    known    = to_simd || (opcode == OPC_FROM_SIMD);
    wide     = opsize && HAS_XMM;
    is_mem   = (modrm[7:6] != 2'b11);
    simd_idx = modrm[5:3];
    gpr_idx  = modrm[2:0];

    raw        = '0;
    raw[FB_UD] = !known || em || (wide && !osfxsr);
    raw[FB_NM] = ts;
    raw[FB_MF] = !wide && fpu_pend;
    raw[FB_GP] = is_mem && ext_gp;
    raw[FB_SS] = is_mem && ext_ss;
    raw[FB_PF] = is_mem && ext_pf;

    // lowest index wins
    fault = '0;
    hit   = 1'b0;
    for (int i = 0; i < FLT_W; i++) begin
      if (raw[i] && !hit) begin
        fault[i] = 1'b1;
        hit      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/simd_mv_rf.sv
module simd_mv_rf #(
  parameter  int W  = 32,
  parameter  int N  = 8,
  parameter  int LW = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [LW-1:0] ra_lo,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign ra_lo   = regs[ra][LW-1:0];
  assign rb_data = regs[rb];
endmodule

// File: rtl/simd_dword_mover.sv
module simd_dword_mover
  import simd_mv_pkg::*;
#(
  parameter bit HAS_XMM = 1'b1,
  parameter int DW      = 32,
  parameter int NW      = 64,
  parameter int WW      = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_opcode,
  input  logic             in_opsize,
  input  logic [7:0]       in_modrm,
  input  logic             cr0_em,
  input  logic             cr0_ts,
  input  logic             cr4_osfxsr,
  input  logic             fpu_pending,
  input  logic             ext_gp,
  input  logic             ext_ss,
  input  logic             ext_pf,
  input  logic             wb_en,
  input  logic [2:0]       wb_idx,
  input  logic [DW-1:0]    wb_data,
  input  logic [1:0]       rd_cls,
  input  logic [2:0]       rd_idx,
  output logic [WW-1:0]    rd_data,
  output logic [DW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             out_done,
  output logic [FLT_W-1:0] out_fault
);
  localparam int IW   = 3;
  localparam int NREG = 1 << IW;

  logic             to_simd, wide, is_mem;
  logic [IW-1:0]    simd_idx, gpr_idx;
  logic [FLT_W-1:0] fault;
  logic             ok;

  simd_mv_decode #(.HAS_XMM(HAS_XMM)) u_dec (
    .opcode   (in_opcode),
    .opsize   (in_opsize),
    .modrm    (in_modrm),
    .em       (cr0_em),
    .ts       (cr0_ts),
    .osfxsr   (cr4_osfxsr),
    .fpu_pend (fpu_pending),
    .ext_gp   (ext_gp),
    .ext_ss   (ext_ss),
    .ext_pf   (ext_pf),
    .to_simd  (to_simd),
    .wide     (wide),
    .is_mem   (is_mem),
    .simd_idx (simd_idx),
    .gpr_idx  (gpr_idx),
    .fault    (fault)
  );

  assign ok = in_valid && (fault == '0);

  // general registers: instruction write wins over writeback
  logic          gpr_ins_we, gpr_we;
  logic [IW-1:0] gpr_wa;
  logic [DW-1:0] gpr_wd, gpr_lo, gpr_rb;
  logic [DW-1:0] simd_lo, load_val;

  assign gpr_ins_we = ok && !to_simd && !is_mem;
  assign gpr_we     = gpr_ins_we || wb_en;
  assign gpr_wa     = gpr_ins_we ? gpr_idx : wb_idx;
  assign gpr_wd     = gpr_ins_we ? simd_lo : wb_data;

  simd_mv_rf #(.W(DW), .N(NREG), .LW(DW)) u_rf_gpr (
    .clk (clk), .rst (rst),
    .we (gpr_we), .wa (gpr_wa), .wd (gpr_wd),
    .ra (gpr_idx), .ra_lo (gpr_lo),
    .rb (rd_idx), .rb_data (gpr_rb)
  );

  assign load_val = is_mem ? mem_rdata : gpr_lo;

  // narrow SIMD registers
  logic          nar_we;
  logic [DW-1:0] nar_lo;
  logic [NW-1:0] nar_rb;

  assign nar_we = ok && to_simd && !wide;

  simd_mv_rf #(.W(NW), .N(NREG), .LW(DW)) u_rf_narrow (
    .clk (clk), .rst (rst),
    .we (nar_we), .wa (simd_idx), .wd ({{(NW-DW){1'b0}}, load_val}),
    .ra (simd_idx), .ra_lo (nar_lo),
    .rb (rd_idx), .rb_data (nar_rb)
  );

  // wide SIMD registers, present only when built
  logic          wid_we;
  logic [DW-1:0] wid_lo;
  logic [WW-1:0] wid_rb;

  assign wid_we = ok && to_simd && wide;

  generate
    if (HAS_XMM) begin : g_wide
      simd_mv_rf #(.W(WW), .N(NREG), .LW(DW)) u_rf_wide (
        .clk (clk), .rst (rst),
        .we (wid_we), .wa (simd_idx), .wd ({{(WW-DW){1'b0}}, load_val}),
        .ra (simd_idx), .ra_lo (wid_lo),
        .rb (rd_idx), .rb_data (wid_rb)
      );
    end else begin : g_no_wide
      assign wid_lo = '0;
      assign wid_rb = '0;
    end
  endgenerate

  assign simd_lo = wide ? wid_lo : nar_lo;

  // single-cycle memory port
  assign mem_addr  = gpr_lo;
  assign mem_we    = ok && !to_simd && is_mem;
  assign mem_wdata = simd_lo;

  // registered status and read-out
  always_ff @(posedge clk) begin
    if (rst) begin
      out_done  <= 1'b0;
      out_fault <= '0;
      rd_data   <= '0;
    end else begin
      out_done  <= in_valid;
      out_fault <= in_valid ? fault : '0;
      case (rcls_e'(rd_cls))
        CLS_GPR:    rd_data <= {{(WW-DW){1'b0}}, gpr_rb};
        CLS_NARROW: rd_data <= {{(WW-NW){1'b0}}, nar_rb};
        CLS_WIDE:   rd_data <= wid_rb;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/simd_mv_checker.sv
module simd_mv_checker
  import simd_mv_pkg::*;
#(
  parameter bit HAS_XMM = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       in_opcode,
  input logic             in_opsize,
  input logic [7:0]       in_modrm,
  input logic             cr0_em,
  input logic             cr0_ts,
  input logic             cr4_osfxsr,
  input logic             fpu_pending,
  input logic             mem_we,
  input logic             out_done,
  input logic [FLT_W-1:0] out_fault
);
  logic opc_ok;
  assign opc_ok = (in_opcode == OPC_TO_SIMD) || (in_opcode == OPC_FROM_SIMD);

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done); // R4
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_done); // R4
  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_fault)); // R4
  AST_EM_GIVES_UD: assert property (@(posedge clk) disable iff (rst)
    in_valid && cr0_em |=> out_fault == 6'b000001); // R5
  AST_TS_GIVES_NM: assert property (@(posedge clk) disable iff (rst)
    in_valid && !cr0_em && cr0_ts && opc_ok && (!in_opsize || cr4_osfxsr)
    |=> out_fault == 6'b000010); // R6
  AST_WIDE_IGNORES_PENDING: assert property (@(posedge clk) disable iff (rst)
    in_valid && HAS_XMM && in_opsize && opc_ok && !cr0_em && !cr0_ts
    && cr4_osfxsr && fpu_pending && (in_modrm[7:6] == 2'b11)
    |=> out_fault == '0); // R7
  AST_STORE_NEEDS_MEM_FORM: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> in_valid && (in_modrm[7:6] != 2'b11)
    && (in_opcode == OPC_FROM_SIMD)); // R3
  AST_STORE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> out_fault == '0); // R9
endmodule

bind simd_dword_mover simd_mv_checker #(.HAS_XMM(HAS_XMM)) u_chk (.*);

// File: tb/simd_dword_mover_bench.sv
`timescale 1ns/1ps
module simd_dword_mover_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_opsize;
  logic [7:0]   in_opcode, in_modrm;
  logic         cr0_em, cr0_ts, cr4_osfxsr, fpu_pending, ext_gp, ext_ss, ext_pf;
  logic         wb_en;
  logic [2:0]   wb_idx, rd_idx;
  logic [31:0]  wb_data;
  logic [1:0]   rd_cls;
  logic [127:0] rd_data, n_rd_data;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata, n_mem_addr, n_mem_wdata;
  logic         mem_we, n_mem_we, out_done, n_done;
  logic [5:0]   out_fault, n_fault;

  logic [31:0]  bmem [16];
  int           nwr;
  int           checks = 0;
  int           fails  = 0;

  always #2.5 clk = ~clk;

  simd_dword_mover u_simd_dword_mover (
    .clk, .rst, .in_valid, .in_opcode, .in_opsize, .in_modrm,
    .cr0_em, .cr0_ts, .cr4_osfxsr, .fpu_pending, .ext_gp, .ext_ss, .ext_pf,
    .wb_en, .wb_idx, .wb_data, .rd_cls, .rd_idx, .rd_data,
    .mem_addr, .mem_we, .mem_wdata, .mem_rdata, .out_done, .out_fault
  );

  simd_dword_mover #(.HAS_XMM(1'b0)) u_simd_dword_mover_narrow (
    .clk, .rst, .in_valid, .in_opcode, .in_opsize, .in_modrm,
    .cr0_em, .cr0_ts, .cr4_osfxsr, .fpu_pending, .ext_gp, .ext_ss, .ext_pf,
    .wb_en, .wb_idx, .wb_data, .rd_cls, .rd_idx, .rd_data (n_rd_data),
    .mem_addr (n_mem_addr), .mem_we (n_mem_we), .mem_wdata (n_mem_wdata),
    .mem_rdata (32'h0), .out_done (n_done), .out_fault (n_fault)
  );

  assign mem_rdata = bmem[mem_addr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) bmem[i] <= 32'h0101_0101 * i;
      bmem[4] <= 32'h1234_5678;
      nwr     <= 0;
    end else if (mem_we) begin
      bmem[mem_addr[3:0]] <= mem_wdata;
      nwr <= nwr + 1;
    end
  end

  // {opcode, prefix, modrm, {em,ts,osfxsr,fpu,gp,ss,pf}, expected fault}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {8'h6E, 1'b0, 8'hF9, 7'b1010000, 6'b000001},
    {8'h6E, 1'b1, 8'hF9, 7'b0000000, 6'b000001},
    {8'h6F, 1'b0, 8'hF9, 7'b0010000, 6'b000001},
    {8'h6E, 1'b0, 8'hF9, 7'b1111000, 6'b000001},
    {8'h6E, 1'b0, 8'hF9, 7'b0111000, 6'b000010},
    {8'h6E, 1'b1, 8'hF9, 7'b0110000, 6'b000010},
    {8'h6E, 1'b0, 8'hF9, 7'b0011000, 6'b000100},
    {8'h6E, 1'b0, 8'h39, 7'b0011111, 6'b000100},
    {8'h6E, 1'b0, 8'h39, 7'b0010111, 6'b001000},
    {8'h6E, 1'b0, 8'h39, 7'b0010011, 6'b010000},
    {8'h6E, 1'b1, 8'h39, 7'b0010001, 6'b100000},
    {8'h7E, 1'b0, 8'h39, 7'b1010000, 6'b000001},
    {8'h7E, 1'b1, 8'h39, 7'b0000000, 6'b000001},
    {8'h7E, 1'b0, 8'h39, 7'b0010001, 6'b100000}
  };

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'b000001: return "R5";
      6'b000010: return "R6";
      6'b000100: return "R7";
      default:   return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] opc, input logic pfx, input logic [7:0] mrm,
                       input logic [6:0] ctl, output logic [5:0] flt, output logic dn);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = opc; in_opsize = pfx; in_modrm = mrm;
    {cr0_em, cr0_ts, cr4_osfxsr, fpu_pending, ext_gp, ext_ss, ext_pf} = ctl;
    @(negedge clk);
    in_valid = 1'b0;
    {cr0_em, cr0_ts, cr4_osfxsr, fpu_pending, ext_gp, ext_ss, ext_pf} = 7'b0010000;
    flt = out_fault; dn = out_done;
  endtask

  task automatic load_gpr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    wb_en = 1'b1; wb_idx = idx; wb_data = val;
    @(negedge clk);
    wb_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] cls, input logic [2:0] idx, output logic [127:0] v);
    @(negedge clk);
    rd_cls = cls; rd_idx = idx;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0]   f;
    logic         d;
    logic [127:0] v;
    rst = 1'b1; in_valid = 1'b0; in_opcode = 8'h0; in_opsize = 1'b0; in_modrm = 8'h0;
    {cr0_em, cr0_ts, cr4_osfxsr, fpu_pending, ext_gp, ext_ss, ext_pf} = 7'b0010000;
    wb_en = 1'b0; wb_idx = 3'd0; wb_data = 32'h0; rd_cls = 2'd0; rd_idx = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    check("R12 done after reset", {127'b0, out_done}, 128'h0);
    check("R12 fault after reset", {122'b0, out_fault}, 128'h0);
    read_reg(2'd2, 3'd5, v);
    check("R12 wide reg after reset", v, 128'h0);

    load_gpr(3'd1, 32'hA5A5_0001);
    load_gpr(3'd2, 32'h0000_0004);
    load_gpr(3'd3, 32'hDEAD_BEEF);
    read_reg(2'd0, 3'd2, v);
    check("R11 gpr read-out", v, 128'h4);
    read_reg(2'd3, 3'd2, v);
    check("R11 class 3 reads zero", v, 128'h0);

    // preload register 7 of both SIMD classes
    issue(8'h6E, 1'b0, 8'hFB, 7'b0010000, f, d);
    issue(8'h6E, 1'b1, 8'hFB, 7'b0010000, f, d);

    // table of faulting instructions
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][29:22], VEC[i][21], VEC[i][20:13], VEC[i][12:6], f, d);
      check({tag_of(VEC[i][5:0]), " fault code"}, {122'b0, f}, {122'b0, VEC[i][5:0]});
      check("R4 done after valid", {127'b0, d}, 128'h1);
    end
    read_reg(2'd1, 3'd7, v);
    check("R9 narrow reg7 untouched", v, 128'hDEAD_BEEF);
    read_reg(2'd2, 3'd7, v);
    check("R9 wide reg7 untouched", v, 128'hDEAD_BEEF);
    check("R9 no memory write", nwr, 0);

    // R4: idle cycle gives no done
    @(negedge clk);
    check("R4 no done when idle", {127'b0, out_done}, 128'h0);

    // R1: register and memory sources into narrow registers
    issue(8'h6E, 1'b0, 8'hD3, 7'b0010000, f, d);
    check("R1 fault", {122'b0, f}, 128'h0);
    read_reg(2'd1, 3'd2, v);
    check("R1 narrow from gpr", v, 128'h0000_0000_DEAD_BEEF);
    issue(8'h6E, 1'b0, 8'h0A, 7'b0010000, f, d);
    read_reg(2'd1, 3'd1, v);
    check("R1 narrow from memory", v, 128'h1234_5678);

    // R2: memory into wide register
    issue(8'h6E, 1'b1, 8'h2A, 7'b0010000, f, d);
    check("R2 fault", {122'b0, f}, 128'h0);
    read_reg(2'd2, 3'd5, v);
    check("R2 wide from memory", v, 128'h1234_5678);

    // R3: SIMD to gpr and to memory
    issue(8'h7E, 1'b1, 8'hEE, 7'b0010000, f, d);
    read_reg(2'd0, 3'd6, v);
    check("R3 wide low to gpr", v, 128'h1234_5678);
    issue(8'h7E, 1'b0, 8'h11, 7'b0010000, f, d);
    check("R3 store data", {96'b0, bmem[1]}, 128'hDEAD_BEEF);
    check("R3 one store", nwr, 1);

    // R7: wide form ignores pending FPU fault
    issue(8'h6E, 1'b1, 8'hF9, 7'b0011000, f, d);
    check("R7 wide ignores pending", {122'b0, f}, 128'h0);
    read_reg(2'd2, 3'd7, v);
    check("R7 wide reg7 written", v, 128'hA5A5_0001);

    // R8: register form ignores translation faults
    issue(8'h6E, 1'b0, 8'hE1, 7'b0010111, f, d);
    check("R8 register form ignores ext", {122'b0, f}, 128'h0);
    read_reg(2'd1, 3'd4, v);
    check("R8 narrow reg4 written", v, 128'hA5A5_0001);

    // R10: narrow-only build runs prefixed form on narrow registers
    load_gpr(3'd0, 32'hCAFE_0000);
    issue(8'h6E, 1'b1, 8'hD8, 7'b0000000, f, d);
    check("R10 main build faults", {122'b0, f}, 128'h1);
    check("R10 narrow build no fault", {122'b0, n_fault}, 128'h0);
    read_reg(2'd1, 3'd3, v);
    check("R10 narrow build mm3", n_rd_data, 128'hCAFE_0000);

    // R12: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_reg(2'd1, 3'd2, v);
    check("R12 narrow cleared by reset", v, 128'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule